// File: doc/BRIEF.md
# Per-Bit Policy Register Bank

This block is a small bank of software-visible registers. Every stored bit is given its own access behaviour when the design is elaborated. Software reaches the bank through a plain synchronous port: address, write enable, read enable, write data with one strobe per byte lane, and registered read data. The hardware side has one status-set input per bit and one event-pulse output per bit.

The behaviour of a bit is chosen by a 4-bit code in the `POLICY_MAP` parameter. The code for flat bit `r*DATA_W + k` (register `r`, bit `k`) sits at `POLICY_MAP[4*(r*DATA_W+k) +: 4]`. `RESET_VAL` holds the reset value of every bit at the same flat index.

The codes are:

| Code | Behaviour |
|------|-----------|
| 0 | plain read/write |
| 1 | read-only status |
| 2 | write-only |
| 3 | cleared by writing 0 |
| 4 | cleared by writing 1 |
| 5 | cleared by any write |
| 6 | cleared by reading |
| 7 | set by reading |
| 8 | set-only |
| 9 | write-once |
| 10 | toggle |
| 11 | write-trigger |
| 12 | reserved |

The registers sit at addresses `0..NUM_REGS-1`. Any other address is unmapped.

Top module: `regbank_top`

## Requirements
- R1: After reset, each register reads back its `RESET_VAL` bits, `rdata` is 0 and `evt_pulse` is 0.
- R2: A write changes only bits whose byte lane strobe is 1. Strobe bit j covers data bits 8j..8j+7. A read/write bit (code 0) takes the written value.
- R3: A read-only bit (code 1) ignores writes. `hw_set` drives it to 1.
- R4: A write-only bit (code 2) always reads as its reset value.
- R5: A code 3 bit goes to 0 when written with 0, and a code 4 bit goes to 0 when written with 1. The other data value leaves either one unchanged.
- R6: A code 5 bit goes to 0 on any write to its byte lane, whatever the data.
- R7: A read returns the current value of a code 6 or code 7 bit. After the read, a code 6 bit is 0 and a code 7 bit is 1. Writes do not change either.
- R8: A set-only bit (code 8) becomes 1 when written with 1. Writing 0 leaves it unchanged.
- R9: A write-once bit (code 9) takes the first write after reset that strobes its lane. It ignores every later write until the next reset.
- R10: A toggle bit (code 10) inverts when written with 1 and holds when written with 0.
- R11: Writing 1 to a write-trigger bit (code 11) raises its `evt_pulse` bit for exactly the one cycle after the write. The bit's read value does not change.
- R12: A reserved bit (code 12) ignores writes and reads as its reset value.
- R13: `hw_set` applies to codes 1, 3, 4, 5 and 6. When `hw_set` and a software clear hit such a bit in the same cycle, the bit ends at 1.
- R14: `rdata` shows the addressed register in the cycle after `rd_en` and is 0 in any other cycle. Accesses to unmapped addresses read 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Byte lane strobes |
| rdata | output | DATA_W | Registered read data |
| hw_set | input | NUM_REGS*DATA_W | Per-bit hardware status set |
| evt_pulse | output | NUM_REGS*DATA_W | Per-bit one-cycle write-trigger event |

## Verification
The hardest case to reach from the ports is a hardware set that lands in the same cycle as a software write that would clear the bit. The bench reaches it by driving `hw_set` for a whole register during the very write cycle that sends all-ones data, and again for all-zeros data. It then reads the register back, so the status bits that should have been cleared must read 1.

The write-once lock is the other case that is hard to reach. It is approached with two writes of complementary data. Read side effects are exposed by reading the same register twice in a row.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [3:0] {
    POL_RW    = 4'd0,
    POL_RO    = 4'd1,
    POL_WO    = 4'd2,
    POL_CLR0  = 4'd3,
    POL_CLR1  = 4'd4,
    POL_CLRW  = 4'd5,
    POL_CLRRD = 4'd6,
    POL_SETRD = 4'd7,
    POL_SET   = 4'd8,
    POL_ONCE  = 4'd9,
    POL_TOG   = 4'd10,
    POL_TRIG  = 4'd11,
    POL_RSVD  = 4'd12
  } bitpol_e;

  localparam int POL_W = 4;

  // Policies whose stored value a hardware set may force to 1
  function automatic logic hw_settable(bitpol_e pol);
    return (pol == POL_RO) || (pol == POL_CLR0) || (pol == POL_CLR1) ||
           (pol == POL_CLRW) || (pol == POL_CLRRD);
  endfunction

  // Policies whose read value is pinned to the reset value
  function automatic logic reads_reset(bitpol_e pol);
    return (pol == POL_WO) || (pol == POL_RSVD);
  endfunction

  // Next stored value of one bit; hardware set is applied last so it wins
  function automatic logic bit_next(bitpol_e pol, logic q, logic locked,
                                    logic wr, logic wb, logic rd, logic hs);
    logic nq;
    nq = q;
    case (pol)
      POL_RW, POL_WO: if (wr) nq = wb;
      POL_CLR0:       if (wr && !wb) nq = 1'b0;
      POL_CLR1:       if (wr && wb) nq = 1'b0;
      POL_CLRW:       if (wr) nq = 1'b0;
      POL_CLRRD:      if (rd) nq = 1'b0;
      POL_SETRD:      if (rd) nq = 1'b1;
      POL_SET:        if (wr && wb) nq = 1'b1;
      POL_ONCE:       if (wr && !locked) nq = wb;
      POL_TOG:        if (wr && wb) nq = ~q;
      default:        nq = q;
    endcase
    if (hs && hw_settable(pol)) nq = 1'b1;
    return nq;
  endfunction

endpackage

// File: rtl/regbank_cell.sv
module regbank_cell #(
  parameter regbank_pkg::bitpol_e POL = regbank_pkg::POL_RW,
  parameter logic RST_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wbit,
  input  logic rd_hit,
  input  logic hw_set,
  output logic rd_val,
  output logic state,
  output logic locked,
  output logic evt
);
  import regbank_pkg::*;

  logic q_d;
  assign q_d = bit_next(POL, state, locked, wr_hit, wbit, rd_hit, hw_set);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RST_BIT;
      locked <= 1'b0;
      evt    <= 1'b0;
    end else begin
      state  <= q_d;
      locked <= locked | ((POL == POL_ONCE) && wr_hit);
      evt    <= (POL == POL_TRIG) && wr_hit && wbit;
    end
  end

  assign rd_val = reads_reset(POL) ? RST_BIT : state;
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 3
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic [NUM_REGS-1:0] rd_sel
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign wr_sel[r] = wr_en && (addr == ADDR_W'(r));
    assign rd_sel[r] = rd_en && (addr == ADDR_W'(r));
  end
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_REGS-1:0]          rd_sel,
  input  logic [NUM_REGS*DATA_W-1:0]   reg_vals,
  output logic [DATA_W-1:0]            rdata
);
  logic [DATA_W-1:0] mux_d;

  always_comb begin
    mux_d = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (rd_sel[r]) mux_d = mux_d | reg_vals[r*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mux_d;
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter logic [4*NUM_REGS*DATA_W-1:0] POLICY_MAP = '0,
  parameter logic [NUM_REGS*DATA_W-1:0]   RESET_VAL  = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [DATA_W/8-1:0]          wstrb,
  output logic [DATA_W-1:0]            rdata,
  input  logic [NUM_REGS*DATA_W-1:0]   hw_set,
  output logic [NUM_REGS*DATA_W-1:0]   evt_pulse
);
  localparam int NBITS = NUM_REGS * DATA_W;

  // Named internal events, observed by the bound checker
  logic [NUM_REGS-1:0] wr_sel, rd_sel;
  logic [NBITS-1:0]    bit_wr, bit_rd;
  logic [NBITS-1:0]    state_q, lock_q, read_val;

  regbank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      localparam int IDX = r * DATA_W + k;
      assign bit_wr[IDX] = wr_sel[r] && wstrb[k/8];
      assign bit_rd[IDX] = rd_sel[r];
      regbank_cell #(
        .POL(regbank_pkg::bitpol_e'(POLICY_MAP[4*IDX +: 4])),
        .RST_BIT(RESET_VAL[IDX])
      ) u_cell (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(bit_wr[IDX]), .wbit(wdata[k]), .rd_hit(bit_rd[IDX]),
        .hw_set(hw_set[IDX]),
        .rd_val(read_val[IDX]), .state(state_q[IDX]),
        .locked(lock_q[IDX]), .evt(evt_pulse[IDX])
      );
    end
  end

  regbank_rdmux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel),
    .reg_vals(read_val), .rdata(rdata)
  );
endmodule

// File: rtl/regbank_sva.sv
module regbank_sva #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  parameter logic [4*NUM_REGS*DATA_W-1:0] POLICY_MAP = '0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [DATA_W-1:0]          rdata,
  input logic [NUM_REGS*DATA_W-1:0] hw_set,
  input logic [NUM_REGS*DATA_W-1:0] evt_pulse,
  input logic [NUM_REGS*DATA_W-1:0] bit_wr,
  input logic [NUM_REGS*DATA_W-1:0] bit_rd,
  input logic [NUM_REGS*DATA_W-1:0] state_q,
  input logic [NUM_REGS*DATA_W-1:0] lock_q,
  input logic [NUM_REGS-1:0]        wr_sel,
  input logic [NUM_REGS-1:0]        rd_sel
);
  import regbank_pkg::*;
  localparam int NBITS = NUM_REGS * DATA_W;

  function automatic logic [NBITS-1:0] mask_of(bitpol_e p);
    logic [NBITS-1:0] m;
    for (int i = 0; i < NBITS; i++) m[i] = (POLICY_MAP[4*i +: 4] == p);
    return m;
  endfunction

  function automatic logic [NBITS-1:0] settable_mask();
    logic [NBITS-1:0] m;
    for (int i = 0; i < NBITS; i++) m[i] = hw_settable(bitpol_e'(POLICY_MAP[4*i +: 4]));
    return m;
  endfunction

  localparam logic [NBITS-1:0] M_CLRRD = mask_of(POL_CLRRD);
  localparam logic [NBITS-1:0] M_SETRD = mask_of(POL_SETRD);
  localparam logic [NBITS-1:0] M_TRIG  = mask_of(POL_TRIG);
  localparam logic [NBITS-1:0] M_HW    = settable_mask();

  // R14: at most one register selected per access
  a_r14_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel) && $onehot0(rd_sel));
  // R14: per-bit read hits only while a read is requested
  a_r14_rd_hits_need_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (|bit_rd) |-> rd_en);
  // R14: no read in the previous cycle means zero read data
  a_r14_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> (rdata == '0));
  // R7: clear-on-read bits are 0 after the read unless hardware set them
  a_r7_clr_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bit_rd & M_CLRRD)) |=> ((state_q & $past(bit_rd & ~hw_set & M_CLRRD)) == '0));
  // R7: set-on-read bits are 1 after the read
  a_r7_set_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bit_rd & M_SETRD)) |=>
      ((state_q & $past(bit_rd & M_SETRD)) == $past(bit_rd & M_SETRD)));
  // R9: a locked write-once bit never changes
  a_r9_once_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (|lock_q) |=> ((state_q & $past(lock_q)) == ($past(state_q) & $past(lock_q))));
  // R11: write-trigger bits keep their stored value across writes
  a_r11_trig_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((state_q & M_TRIG) == ($past(state_q) & M_TRIG)));
  // R11: an event bit only follows a write hit on a trigger bit
  a_r11_evt_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |-> ((evt_pulse & ~$past(bit_wr & M_TRIG)) == '0));
  // R13: a hardware set always leaves the bit at 1
  a_r13_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set & M_HW)) |=> ((state_q & $past(hw_set & M_HW)) == $past(hw_set & M_HW)));
endmodule

bind regbank_top regbank_sva #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .POLICY_MAP(POLICY_MAP)
) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
  .hw_set(hw_set), .evt_pulse(evt_pulse), .bit_wr(bit_wr), .bit_rd(bit_rd),
  .state_q(state_q), .lock_q(lock_q), .wr_sel(wr_sel), .rd_sel(rd_sel)
);

// File: tb/tb_regbank_top.sv
`timescale 1ns/1ps
module tb_regbank_top;
  localparam int NR = 4, DW = 16, NB = NR * DW, AW = 3;
  localparam logic [NB-1:0] RV = {4{16'h5A3C}};

  localparam int P_RW = 0, P_RO = 1, P_WO = 2, P_C0 = 3, P_C1 = 4, P_CW = 5,
                 P_CR = 6, P_SR = 7, P_SET = 8, P_ONCE = 9, P_TOG = 10,
                 P_TRIG = 11, P_RSV = 12;

  function automatic logic [4*NB-1:0] mk_map();
    logic [4*NB-1:0] m;
    for (int i = 0; i < NB; i++) m[4*i +: 4] = 4'(i % 13);
    return m;
  endfunction
  localparam logic [4*NB-1:0] MAP = mk_map();

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] wstrb = '0;
  logic [DW-1:0] rdata;
  logic [NB-1:0] hw_set = '0;
  logic [NB-1:0] evt_pulse;

  int checks = 0, errors = 0;
  bit done = 0;
  logic mq [NB];
  logic mlk [NB];

  always #2 clk = ~clk;

  regbank_top #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW),
                .POLICY_MAP(MAP), .RESET_VAL(RV)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .hw_set(hw_set),
    .evt_pulse(evt_pulse)
  );

  function automatic int pol(int i); return i % 13; endfunction

  function automatic bit settable(int p);
    return p == P_RO || p == P_C0 || p == P_C1 || p == P_CW || p == P_CR;
  endfunction

  function automatic string tag_of(int p);
    case (p)
      P_RW: return "R2";  P_RO: return "R3";  P_WO: return "R4";
      P_C0, P_C1: return "R5";  P_CW: return "R6";
      P_CR, P_SR: return "R7";  P_SET: return "R8";  P_ONCE: return "R9";
      P_TOG: return "R10";  P_TRIG: return "R11";  default: return "R12";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [NB-1:0] act, logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin mq[i] = RV[i]; mlk[i] = 0; end
  endtask

  task automatic chk_reg(int r, logic [DW-1:0] got, string tag);
    for (int p = 0; p < 13; p++) begin
      logic [DW-1:0] m = '0, e = '0;
      for (int k = 0; k < DW; k++) begin
        int i = r * DW + k;
        if (pol(i) == p) begin
          m[k] = 1;
          e[k] = (p == P_WO || p == P_RSV) ? RV[i] : mq[i];
        end
      end
      if (m != '0)
        check((got & m) == e, (tag != "") ? tag : tag_of(p),
              NB'(got & m), NB'(e));
    end
  endtask

  task automatic do_write(int r, logic [DW-1:0] d, logic [1:0] s, logic [NB-1:0] h);
    logic [NB-1:0] eev = '0;
    addr = AW'(r); wdata = d; wstrb = s; wr_en = 1; hw_set = h;
    @(posedge clk); #1;
    wr_en = 0; hw_set = '0;
    if (r < NR) begin
      for (int k = 0; k < DW; k++) begin
        int i = r * DW + k;
        logic ln = s[k/8];
        logic wb = d[k];
        if (ln) case (pol(i))
          P_RW, P_WO: mq[i] = wb;
          P_C0: if (!wb) mq[i] = 0;
          P_C1: if (wb) mq[i] = 0;
          P_CW: mq[i] = 0;
          P_SET: if (wb) mq[i] = 1;
          P_ONCE: if (!mlk[i]) begin mq[i] = wb; mlk[i] = 1; end
          P_TOG: if (wb) mq[i] = ~mq[i];
          P_TRIG: if (wb) eev[i] = 1;
          default: ;
        endcase
      end
    end
    for (int i = 0; i < NB; i++) if (h[i] && settable(pol(i))) mq[i] = 1;
    check(evt_pulse == eev, "R11", evt_pulse, eev);
    @(posedge clk); #1;
    check(evt_pulse == '0, "R11", evt_pulse, '0);
    check(rdata == '0, "R14", NB'(rdata), '0);
  endtask

  task automatic do_hw(logic [NB-1:0] h);
    hw_set = h;
    @(posedge clk); #1;
    hw_set = '0;
    for (int i = 0; i < NB; i++) if (h[i] && settable(pol(i))) mq[i] = 1;
  endtask

  task automatic do_read(int r, string tag);
    addr = AW'(r); rd_en = 1;
    @(posedge clk); #1;
    rd_en = 0;
    if (r < NR) begin
      chk_reg(r, rdata, tag);
      for (int k = 0; k < DW; k++) begin
        int i = r * DW + k;
        if (pol(i) == P_CR) mq[i] = 0;
        if (pol(i) == P_SR) mq[i] = 1;
      end
    end else check(rdata == '0, "R14", NB'(rdata), '0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check(rdata == '0, "R1", NB'(rdata), '0);
    check(evt_pulse == '0, "R1", evt_pulse, '0);
    rst_n = 1;
    model_reset();
    @(posedge clk); #1;
    check(rdata == '0, "R14", NB'(rdata), '0);
    for (int r = 0; r < NR; r++) do_read(r, "R1");
  endtask

  task automatic t_full_writes();
    for (int r = 0; r < NR; r++) begin do_write(r, 16'hFFFF, 2'b11, '0); do_read(r, ""); end
    for (int r = 0; r < NR; r++) begin do_write(r, 16'h0000, 2'b11, '0); do_read(r, ""); end
    for (int r = 0; r < NR; r++) begin do_write(r, 16'hA5C3, 2'b11, '0); do_read(r, ""); end
  endtask

  task automatic t_strobes();
    do_write(1, 16'hFFFF, 2'b01, '0); do_read(1, "");
    do_write(1, 16'h0000, 2'b10, '0); do_read(1, "");
    do_write(3, 16'h00FF, 2'b00, '0); do_read(3, "R2");
  endtask

  task automatic t_reads_twice();
    do_hw({NB{1'b1}});
    for (int r = 0; r < NR; r++) begin do_read(r, "R7"); do_read(r, "R7"); end
  endtask

  task automatic t_once_and_toggle();
    do_write(0, 16'h1234, 2'b11, '0); do_read(0, "");
    do_write(0, 16'hEDCB, 2'b11, '0); do_read(0, "R9");
    do_write(2, 16'hFFFF, 2'b11, '0); do_read(2, "R10");
    do_write(2, 16'hFFFF, 2'b11, '0); do_read(2, "R10");
  endtask

  task automatic t_trigger();
    for (int r = 0; r < NR; r++) do_write(r, 16'hFFFF, 2'b11, '0);
    for (int r = 0; r < NR; r++) do_read(r, "");
  endtask

  task automatic t_hw_race();
    do_write(1, 16'hFFFF, 2'b11, {NB{1'b1}}); do_read(1, "R13");
    do_write(2, 16'h0000, 2'b11, {NB{1'b1}}); do_read(2, "R13");
    do_write(3, 16'h5555, 2'b11, {NB{1'b1}}); do_read(3, "R13");
  endtask

  task automatic t_ro_status();
    for (int r = 0; r < NR; r++) do_write(r, 16'h0000, 2'b11, '0);
    do_hw(64'h0123_4567_89AB_CDEF);
    for (int r = 0; r < NR; r++) do_read(r, "R3");
  endtask

  task automatic t_unmapped();
    do_write(5, 16'hFFFF, 2'b11, '0);
    do_write(7, 16'h0000, 2'b11, '0);
    do_read(5, "R14"); do_read(6, "R14");
    for (int r = 0; r < NR; r++) do_read(r, "R14");
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_full_writes();
    t_strobes();
    t_reads_twice();
    t_once_and_toggle();
    t_trigger();
    t_hw_race();
    t_ro_status();
    t_unmapped();
    finish_run();
  end
endmodule